// File: doc/BRIEF.md
# Way-Predicted Four-Way Cache Lookup Controller

This block performs read lookups into a four-way set-associative cache. Each way keeps its tag, valid and data storage as separate sub-arrays, and each sub-array has its own enable. A per-set predictor chooses one way to probe first. Only that way's tag is read in the first lookup cycle. If the probe misses, a second cycle reads all four tags. The data sub-array of the matching way is read only after a match has been established. A miss reads no data at all.

A requester presents an address made of a tag and a set index. There is one word per line, so the address has no offset bits. The block answers with a response that carries a hit flag and the word that was read. After a miss response has been taken, the block asks for a refill. The refilled word is installed into a victim way, which is chosen by the replacement policy set at build time: least recently used, first-in first-out, or pseudo-random. Throughout operation the block keeps a running energy figure. It is built from the sub-array enables that fire in each cycle, with each kind of sub-array given its own weight.

Top module: `wpc_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `fill_ready` are 0, and `energy` is 0.
- R2: At most one access is in flight at a time. `req_ready` falls only in the cycle after a request is accepted. It stays low until the hit response has been taken, or until the refill that follows a miss has been taken.
- R3: The address is `{tag, set}`, with the set in the low 4 bits. The first lookup cycle enables only the predicted way's tag sub-array. If that way is valid and its tag matches, `rsp_valid` rises two clocks after the accepting edge, with `rsp_hit`=1 and the stored word.
- R4: If the predicted probe fails, one extra cycle enables all four tag sub-arrays. If a way matches there, the hit response rises three clocks after the accepting edge.
- R5: On a miss, no data sub-array is enabled. The response has `rsp_hit`=0 and `rsp_data`=0, and `rsp_valid` rises two clocks after acceptance. Once that response is taken, `fill_ready` stays high until `fill_valid`. The word is then written, with the request's tag, into the victim way. A tag never resides in two ways of the same set.
- R6: The victim is the lowest-numbered invalid way of the set. If all four ways are valid, the policy picks: the least recently used way (age rank 3) under LRU, a per-set rotating 2-bit pointer under FIFO, or the low 2 bits of a 16-bit LFSR under random.
- R7: After reset, every set predicts way 0. A hit found in the fallback cycle sets that set's prediction to the hitting way. A refill sets it to the filled way.
- R8: Under LRU, the replacement sub-arrays of all four ways are enabled in the data cycle of every hit and in the refill cycle. Under FIFO they are enabled only in the refill cycle. Under random they are never enabled.
- R9: In every cycle, `energy` grows by 20 for each data sub-array enabled, 5 for each tag sub-array enabled and 1 for each replacement sub-array enabled. The refill cycle enables the victim's tag and data sub-arrays for writing.
- R10: `energy` saturates at its all-ones value and never decreases while out of reset.
- R11: Sets are independent. A tag installed in one set does not hit in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | TAG_W+log2(SETS) | Tag in upper bits, set index in lower bits |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_data | output | DATA_W | Word read on a hit, 0 on a miss |
| fill_valid | input | 1 | Refill word present |
| fill_ready | output | 1 | Block waits for a refill |
| fill_data | input | DATA_W | Word to install |
| energy | output | ENERGY_W | Saturating weighted enable count |

## Verification
The refill cycle is the busiest point of the block. In that one clock it writes the victim's tag and data sub-arrays, retargets the predictor, and, under LRU or FIFO, touches the replacement state. All of these enables must be charged together in the same energy step. The bench provokes this cycle by filling one set with four tags and then forcing a fifth. It judges the result three ways: by the energy increase for that access, by whether the next request to the filled tag is answered on the short probe path, and by which older tag now misses. A second overlap is the fallback hit, where the predictor update and the data read fall on adjacent cycles. That case is checked through the three-clock latency and through a one-probe hit on the following access.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    REPL_LRU    = 2'd0,
    REPL_FIFO   = 2'd1,
    REPL_RANDOM = 2'd2
  } repl_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROBE, ST_SCAN, ST_DATA, ST_RESP, ST_FILL
  } state_e;

  localparam int unsigned NUM_WAYS    = 4;
  localparam int unsigned WAY_W       = 2;
  localparam int unsigned COST_DATA   = 20;
  localparam int unsigned COST_TAG    = 5;
  localparam int unsigned COST_REPL   = 1;
endpackage

// File: rtl/wpc_way_array.sv
module wpc_way_array #(
  parameter int unsigned SETS   = 16,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_rd,
  input  logic              data_rd,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              valid_o
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [DATA_W-1:0] dat_mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q      <= '0;
    else if (wr_en) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[idx] <= cmp_tag;
      dat_mem[idx] <= wr_data;
    end
  end

  assign hit     = tag_rd & vld_q[idx] & (tag_mem[idx] == cmp_tag);
  assign rd_data = data_rd ? dat_mem[idx] : '0;
  assign valid_o = vld_q[idx];
endmodule

// File: rtl/wpc_repl.sv
module wpc_repl #(
  parameter int unsigned     SETS   = 16,
  parameter wpc_pkg::repl_e  POLICY = wpc_pkg::REPL_LRU,
  localparam int unsigned    IDX_W  = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       valid_set,
  input  logic             hit_upd,
  input  logic             fill_upd,
  input  logic [1:0]       touch_way,
  output logic [1:0]       victim,
  output logic             repl_on
);
  logic [1:0] policy_way;
  logic [1:0] inv_way;
  logic       have_inv;

  always_comb begin
    inv_way  = 2'd0;
    have_inv = 1'b0;
    for (int w = 3; w >= 0; w--) begin
      if (!valid_set[w]) begin
        inv_way  = 2'(w);
        have_inv = 1'b1;
      end
    end
  end

  assign victim = have_inv ? inv_way : policy_way;

  generate
    if (POLICY == wpc_pkg::REPL_LRU) begin : g_lru
      logic [1:0] age_q [SETS][4];
      logic [1:0] age_d [4];

      always_comb begin
        policy_way = 2'd0;
        for (int w = 0; w < 4; w++)
          if (age_q[idx][w] == 2'd3) policy_way = 2'(w);
      end

      always_comb begin
        for (int w = 0; w < 4; w++) begin
          if (2'(w) == touch_way)                         age_d[w] = 2'd0;
          else if (age_q[idx][w] < age_q[idx][touch_way]) age_d[w] = age_q[idx][w] + 2'd1;
          else                                            age_d[w] = age_q[idx][w];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < int'(SETS); s++)
            for (int w = 0; w < 4; w++) age_q[s][w] <= 2'(w);
        end else if (hit_upd | fill_upd) begin
          for (int w = 0; w < 4; w++) age_q[idx][w] <= age_d[w];
        end
      end

      assign repl_on = hit_upd | fill_upd;

      AST_LRU_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_upd | fill_upd) |=> age_q[$past(idx)][$past(touch_way)] == 2'd0); // R6
    end else if (POLICY == wpc_pkg::REPL_FIFO) begin : g_fifo
      logic [1:0] ptr_q [SETS];
      logic       unused_fifo;

      assign policy_way  = ptr_q[idx];
      assign unused_fifo = ^{hit_upd, touch_way};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < int'(SETS); s++) ptr_q[s] <= 2'd0;
        end else if (fill_upd) begin
          ptr_q[idx] <= ptr_q[idx] + 2'd1;
        end
      end

      assign repl_on = fill_upd;
    end else begin : g_rnd
      logic [15:0] lfsr_q;
      logic        fb;
      logic        unused_rnd;

      assign fb         = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
      assign policy_way = lfsr_q[1:0];
      assign unused_rnd = ^{hit_upd, fill_upd, touch_way, idx};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= 16'hACE1;
        else        lfsr_q <= {lfsr_q[14:0], fb};
      end

      assign repl_on = 1'b0;

      AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'd0); // R6
    end
  endgenerate
endmodule

// File: rtl/wpc_energy.sv
module wpc_energy #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   tag_chg,
  input  logic [3:0]   data_chg,
  input  logic         repl_on,
  output logic [W-1:0] total
);
  logic [7:0]   cost;
  logic [W:0]   sum;
  logic [W-1:0] total_q, total_d;
  logic         cnt_en;

  always_comb begin
    cost = 8'(wpc_pkg::COST_DATA * $countones(data_chg))
         + 8'(wpc_pkg::COST_TAG  * $countones(tag_chg))
         + (repl_on ? 8'(wpc_pkg::COST_REPL * wpc_pkg::NUM_WAYS) : 8'd0);
    sum     = {1'b0, total_q} + (W+1)'(cost);
    total_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
    cnt_en  = (|tag_chg) | (|data_chg) | repl_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total_q <= '0;
    else if (cnt_en) total_q <= total_d;
  end

  assign total = total_q;

  AST_ENERGY_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> total_q >= $past(total_q)); // R10
  AST_ENERGY_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(total_q) == {W{1'b1}}) |-> total_q == {W{1'b1}}); // R10
endmodule

// File: rtl/wpc_lookup.sv
module wpc_lookup
  import wpc_pkg::*;
#(
  parameter int unsigned SETS     = 16,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ENERGY_W = 32,
  parameter repl_e       POLICY   = REPL_LRU,
  localparam int unsigned IDX_W   = $clog2(SETS),
  localparam int unsigned ADDR_W  = TAG_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic                fill_valid,
  output logic                fill_ready,
  input  logic [DATA_W-1:0]   fill_data,
  output logic [ENERGY_W-1:0] energy
);
  state_e             state_q, state_d;
  logic [TAG_W-1:0]   tag_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WAY_W-1:0]   way_q, way_d, hit_idx, victim, touch_way, pred_d;
  logic [WAY_W-1:0]   pred_q [SETS];
  logic               rsp_hit_q, rsp_hit_d;
  logic [DATA_W-1:0]  rsp_data_q, rsp_data_d, data_mux;
  logic               cap_en, way_en, rsp_en, pred_en;
  logic [NUM_WAYS-1:0] tag_rd, data_rd, wr_vec, way_hit, set_valid;
  logic [DATA_W-1:0]  way_rdata [NUM_WAYS];
  logic               hit_upd, fill_upd, repl_on;

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      wpc_way_array #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_rd  (tag_rd[w]),
        .data_rd (data_rd[w]),
        .wr_en   (wr_vec[w]),
        .idx     (idx_q),
        .cmp_tag (tag_q),
        .wr_data (fill_data),
        .hit     (way_hit[w]),
        .rd_data (way_rdata[w]),
        .valid_o (set_valid[w])
      );
    end
  endgenerate

  always_comb begin
    hit_idx  = '0;
    data_mux = '0;
    for (int w = 0; w < int'(NUM_WAYS); w++) begin
      if (way_hit[w]) hit_idx = WAY_W'(w);
      data_mux = data_mux | way_rdata[w];
    end
  end

  assign hit_upd   = (state_q == ST_DATA);
  assign fill_upd  = (state_q == ST_FILL) && fill_valid;
  assign touch_way = hit_upd ? way_q : victim;

  wpc_repl #(.SETS(SETS), .POLICY(POLICY)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx_q),
    .valid_set (set_valid),
    .hit_upd   (hit_upd),
    .fill_upd  (fill_upd),
    .touch_way (touch_way),
    .victim    (victim),
    .repl_on   (repl_on)
  );

  wpc_energy #(.W(ENERGY_W)) u_energy (
    .clk      (clk),
    .rst_n    (rst_n),
    .tag_chg  (tag_rd | wr_vec),
    .data_chg (data_rd | wr_vec),
    .repl_on  (repl_on),
    .total    (energy)
  );

  // Next-state and enable decode
  always_comb begin
    state_d    = state_q;
    cap_en     = 1'b0;
    way_en     = 1'b0;
    way_d      = way_q;
    rsp_en     = 1'b0;
    rsp_hit_d  = rsp_hit_q;
    rsp_data_d = rsp_data_q;
    pred_en    = 1'b0;
    pred_d     = pred_q[idx_q];
    tag_rd     = '0;
    data_rd    = '0;
    wr_vec     = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        cap_en  = 1'b1;
        state_d = ST_PROBE;
      end
      ST_PROBE: begin
        tag_rd = NUM_WAYS'(1) << pred_q[idx_q];
        if (|way_hit) begin
          way_en  = 1'b1;
          way_d   = pred_q[idx_q];
          state_d = ST_DATA;
        end else begin
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        tag_rd = '1;
        if (|way_hit) begin
          way_en  = 1'b1;
          way_d   = hit_idx;
          pred_en = 1'b1;
          pred_d  = hit_idx;
          state_d = ST_DATA;
        end else begin
          rsp_en     = 1'b1;
          rsp_hit_d  = 1'b0;
          rsp_data_d = '0;
          state_d    = ST_RESP;
        end
      end
      ST_DATA: begin
        data_rd    = NUM_WAYS'(1) << way_q;
        rsp_en     = 1'b1;
        rsp_hit_d  = 1'b1;
        rsp_data_d = data_mux;
        state_d    = ST_RESP;
      end
      ST_RESP: if (rsp_ready) state_d = rsp_hit_q ? ST_IDLE : ST_FILL;
      ST_FILL: if (fill_valid) begin
        wr_vec  = NUM_WAYS'(1) << victim;
        pred_en = 1'b1;
        pred_d  = victim;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tag_q      <= '0;
      idx_q      <= '0;
      way_q      <= '0;
      rsp_hit_q  <= 1'b0;
      rsp_data_q <= '0;
      for (int s = 0; s < int'(SETS); s++) pred_q[s] <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en)  {tag_q, idx_q} <= req_addr;
      if (way_en)  way_q <= way_d;
      if (rsp_en) begin
        rsp_hit_q  <= rsp_hit_d;
        rsp_data_q <= rsp_data_d;
      end
      if (pred_en) pred_q[idx_q] <= pred_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign fill_ready = (state_q == ST_FILL);
  assign rsp_hit    = rsp_hit_q;
  assign rsp_data   = rsp_data_q;

  AST_READY_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid)); // R2
  AST_SCAN_AFTER_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> $past(state_q) == ST_PROBE); // R4
  AST_MISS_NO_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && !rsp_hit) |-> $past(data_rd) == '0); // R5
  AST_SINGLE_TAG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_hit) <= 1); // R5
  AST_FILL_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_ready) |-> $past(rsp_valid && rsp_ready && !rsp_hit)); // R5
  AST_PRED_LEARNS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && (|way_hit)) |=> pred_q[idx_q] == $past(hit_idx)); // R7
endmodule

// File: tb/wpc_lookup_bench.sv
module wpc_lookup_bench;
  timeunit 1ns;
  timeprecision 1ps;
  import wpc_pkg::*;

  localparam int SETS = 16, TAG_W = 8, DATA_W = 16, NI = 3;

  logic clk, rst_n;
  logic [NI-1:0] req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit, fill_valid, fill_ready;
  logic [TAG_W+3:0]  req_addr;
  logic [DATA_W-1:0] fill_data;
  logic [DATA_W-1:0] rsp_data [NI];
  logic [31:0] energy0, energy1;
  logic [7:0]  energy2;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  wpc_lookup #(.POLICY(REPL_LRU)) u_wpc_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_addr(req_addr), .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]),
    .rsp_hit(rsp_hit[0]), .rsp_data(rsp_data[0]), .fill_valid(fill_valid[0]),
    .fill_ready(fill_ready[0]), .fill_data(fill_data), .energy(energy0));

  wpc_lookup #(.POLICY(REPL_FIFO)) u_wpc_lookup_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_addr(req_addr), .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]),
    .rsp_hit(rsp_hit[1]), .rsp_data(rsp_data[1]), .fill_valid(fill_valid[1]),
    .fill_ready(fill_ready[1]), .fill_data(fill_data), .energy(energy1));

  wpc_lookup #(.POLICY(REPL_RANDOM), .ENERGY_W(8)) u_wpc_lookup_rnd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[2]), .req_ready(req_ready[2]),
    .req_addr(req_addr), .rsp_valid(rsp_valid[2]), .rsp_ready(rsp_ready[2]),
    .rsp_hit(rsp_hit[2]), .rsp_data(rsp_data[2]), .fill_valid(fill_valid[2]),
    .fill_ready(fill_ready[2]), .fill_data(fill_data), .energy(energy2));

  int n_chk, n_fail;
  bit          mv [SETS][4];
  logic [7:0]  mt [SETS][4];
  logic [1:0]  mp [SETS];
  logic [1:0]  ma [SETS][4];
  longint      esum [NI];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(input logic [7:0] t, input int s);
    return {4'hA, t, 4'(s)} ^ 16'h3C5A;
  endfunction

  function automatic int find_way(input logic [7:0] t, input int s);
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int pick_victim(input int s);
    for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
    for (int w = 0; w < 4; w++) if (ma[s][w] == 2'd3) return w;
    return 0;
  endfunction

  task automatic lru_touch(input int s, input int w);
    logic [1:0] a;
    a = ma[s][w];
    for (int v = 0; v < 4; v++) if (ma[s][v] < a) ma[s][v] = ma[s][v] + 2'd1;
    ma[s][w] = 2'd0;
  endtask

  task automatic run_one(input int k, input logic [7:0] t, input int s,
                         input int kind, input string rq);
    int lat;
    longint cost, act, exp;
    string erq;
    @(negedge clk);
    chk(req_ready[k], "R2", "ready before request", req_ready[k], 1);
    req_addr     = {t, 4'(s)};
    req_valid[k] = 1'b1;
    @(negedge clk);
    req_valid[k] = 1'b0;
    chk(!req_ready[k], "R2", "ready low while busy", req_ready[k], 0);
    lat = 0;
    while (!rsp_valid[k] && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == ((kind == 1) ? 3 : 2), rq, "response latency", lat, (kind == 1) ? 3 : 2);
    chk(rsp_hit[k] == (kind != 2), rq, "hit flag", rsp_hit[k], (kind != 2));
    chk(rsp_data[k] == ((kind == 2) ? '0 : word_of(t, s)), rq, "response word",
        rsp_data[k], (kind == 2) ? 0 : word_of(t, s));
    rsp_ready[k] = 1'b1;
    @(negedge clk);
    rsp_ready[k] = 1'b0;
    if (kind == 2) begin
      chk(fill_ready[k], "R5", "refill requested", fill_ready[k], 1);
      chk(!req_ready[k], "R2", "ready low before refill", req_ready[k], 0);
      fill_data     = word_of(t, s);
      fill_valid[k] = 1'b1;
      @(negedge clk);
      fill_valid[k] = 1'b0;
      chk(!fill_ready[k], "R5", "refill request cleared", fill_ready[k], 0);
    end
    chk(req_ready[k], "R2", "ready after completion", req_ready[k], 1);
    // R8 / R9 weights: probe 5, scan 20, data 20, replacement 4, refill 25
    case (kind)
      0:       cost = 25 + ((k == 0) ? 4 : 0);
      1:       cost = 45 + ((k == 0) ? 4 : 0);
      default: cost = 50 + ((k < 2) ? 4 : 0);
    endcase
    esum[k] += cost;
    exp = (k == 2 && esum[k] > 255) ? 255 : esum[k];
    act = (k == 0) ? longint'(energy0) : (k == 1) ? longint'(energy1) : longint'(energy2);
    erq = (k == 2 && esum[k] > 255) ? "R10" : ((k == 0) ? "R9" : "R8");
    chk(act == exp, erq, "energy total", act, exp);
  endtask

  task automatic access(input logic [7:0] t, input int s, input bit [NI-1:0] mask,
                        input string rq);
    int w, kind, v;
    w    = find_way(t, s);
    kind = (w < 0) ? 2 : ((2'(w) == mp[s]) ? 0 : 1);
    for (int k = 0; k < NI; k++) if (mask[k]) run_one(k, t, s, kind, rq);
    if (w >= 0) begin
      if (kind == 1) mp[s] = 2'(w);
      lru_touch(s, w);
    end else begin
      v = pick_victim(s);
      mv[s][v] = 1'b1;
      mt[s][v] = t;
      mp[s]    = 2'(v);
      lru_touch(s, v);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1ms;
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    report();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    req_valid = '0; rsp_ready = '0; fill_valid = '0;
    req_addr = '0; fill_data = '0;
    for (int s = 0; s < SETS; s++) begin
      mp[s] = 2'd0;
      for (int w = 0; w < 4; w++) begin
        mv[s][w] = 1'b0; mt[s][w] = '0; ma[s][w] = 2'(w);
      end
    end
    for (int k = 0; k < NI; k++) esum[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 3'b111, "R1", "req_ready", req_ready, 3'b111);
    chk(rsp_valid == 3'b000, "R1", "rsp_valid", rsp_valid, 0);
    chk(fill_ready == 3'b000, "R1", "fill_ready", fill_ready, 0);
    chk(energy0 == 0 && energy1 == 0 && energy2 == 0, "R1", "energy", energy0, 0);

    access(8'h11, 3, 3'b111, "R5");  // cold miss
    access(8'h11, 3, 3'b111, "R7");  // predictor points at filled way
    access(8'h22, 3, 3'b111, "R4");  // probe fails, scan misses
    access(8'h11, 3, 3'b111, "R4");  // fallback hit
    access(8'h11, 3, 3'b111, "R7");  // predictor learned fallback way
    access(8'h33, 3, 3'b111, "R5");
    access(8'h44, 3, 3'b111, "R5");
    access(8'h22, 3, 3'b111, "R3");
    access(8'h22, 3, 3'b111, "R3");

    // R11 sweep across sets
    for (int s = 0; s < SETS; s++) begin
      if (s == 3) continue;
      access(8'h60 + 8'(s), s, 3'b111, "R11");
      access(8'h60 + 8'(s), s, 3'b111, "R11");
    end
    for (int s = 0; s < SETS; s++) begin
      if (s == 2 || s == 3) continue;
      access(8'h60 + 8'(s), (s + 1) % SETS, 3'b111, "R11");
    end

    // R6 eviction in a full set, least-recently-used instance only
    access(8'h55, 3, 3'b001, "R6");
    access(8'h11, 3, 3'b001, "R6");
    access(8'h22, 3, 3'b001, "R6");
    access(8'h33, 3, 3'b001, "R6");
    access(8'h44, 3, 3'b001, "R6");
    access(8'h55, 3, 3'b001, "R6");
    report();
  end
endmodule